// File: doc/BRIEF.md
# Four-Channel DMA Controller Register File

This block is the host-facing register file of a four-channel DMA controller. A processor reaches it over an 8-bit I/O bus with a 4-bit port offset, a chip select, and single-cycle read and write strobes. The data bus is bidirectional. Each channel has a 16-bit address and a 16-bit count, and each of these has a base copy and a current copy. Each 16-bit value sits behind a single 8-bit port. One byte-pointer flip-flop is shared by all of those ports and decides whether an access reaches the low byte or the high byte.

Some ports hold a value: command, request, mode and mask. Other ports take an action as soon as they are written, with the data ignored: clearing the byte pointer, master reset, and clearing every mask. The per-channel mode fields, the mask vector, the current address and count, and a vector of serviceable requests go out to the channel sequencers. The sequencers send back hardware requests, single-cycle step pulses and terminal-count pulses. Bus arbitration and memory cycles are handled outside this block.

Top module: `dma_regfile`

## Requirements
- R1: After reset every mask bit is set, every mode field is 0, the command register is 0, the terminal-count and software-request flags are clear, and the byte pointer selects the low byte.
- R2: A write to offsets 0..7 loads one byte of both the base copy and the current copy: the low byte when the pointer is 0 and the high byte when it is 1. Offset 2n addresses channel n's address and offset 2n+1 its count. Every read or write to offsets 0..7 toggles the pointer, and any write to offset 0xC forces it to 0.
- R3: A read of offsets 0..7 returns the selected byte of the channel's current address (even offset) or current count (odd offset). The byte is chosen by the same pointer, low byte first.
- R4: A write to offset 0xB stores data bits 7:2 as the mode of the channel named by bits 1:0, and the field appears at mode_o[6n+5:6n]. Within the field, bits 1:0 are the transfer type, bit 2 enables auto-initialise, bit 3 selects decrement, and bits 5:4 are the mode.
- R5: A write to offset 0xA sets (data bit 2 = 1) or clears (data bit 2 = 0) the mask bit of the channel in bits 1:0. A write to 0xE clears all four mask bits. A write to 0xF copies data bits 3:0 into the four mask bits.
- R6: Any write to offset 0xD clears the byte pointer, the terminal-count flags and the software requests, and sets all four mask bits. This takes precedence over a terminal-count pulse in the same cycle.
- R7: A read of offset 8 returns the pending requests (hardware or software) of channels 3..0 in bits 7:4 and the terminal-count flags of channels 3..0 in bits 3:0. The read clears the terminal-count flags, except for any flag whose terminal-count pulse arrives in that same cycle.
- R8: A write to offset 8 stores the command byte. While command bit 2 is set, ctrl_off_o is high and svc_req_o is 0. Otherwise svc_req_o[n] is high when channel n has a pending request and is unmasked.
- R9: A write to offset 9 sets (data bit 2 = 1) or clears (data bit 2 = 0) the software request of the channel in bits 1:0.
- R10: A step pulse on a channel decrements its current count, wrapping from 0x0000 to 0xFFFF. It also moves the current address by one: down when mode bit 3 is set, up otherwise.
- R11: A terminal-count pulse sets the channel's status flag. If the channel has auto-initialise set, the pulse also reloads the current address and count from their base copies, taking precedence over a step in the same cycle. A bus write to any of the channel's ports takes precedence over both.
- R12: Reads of offsets 9..0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one access per cycle |
| wr | input | 1 | Write strobe, one access per cycle |
| addr | input | 4 | Port offset |
| data | inout | 8 | Bidirectional data; driven by the block while cs and rd are high |
| step_i | input | 4 | Per-channel transfer step pulse |
| tc_i | input | 4 | Per-channel terminal-count pulse |
| req_i | input | 4 | Per-channel hardware request |
| mode_o | output | 24 | Six mode bits per channel |
| mask_o | output | 4 | Per-channel mask |
| svc_req_o | output | 4 | Requests that may be serviced |
| cur_addr_o | output | 64 | Current address, 16 bits per channel |
| cur_cnt_o | output | 64 | Current count, 16 bits per channel |
| ctrl_off_o | output | 1 | Controller disabled by command bit 2 |

## Verification
A byte pointer in the wrong state shows up on the very next channel-port access. The read returns the other half of the word, or the write lands in the wrong half, and the current address or count outputs show the result one clock later. Wrong mask, mode, command or counter state shows on mask_o, mode_o, svc_req_o, cur_addr_o and cur_cnt_o in the cycle after the edge that corrupted it. A wrong terminal-count flag is seen on the next status read. The bench compares every output against a behavioural model after every clock, so any divergence is reported within one cycle of its cause.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [3:0]        addr,
  inout  wire  [DW-1:0]     data,
  input  logic [3:0]        step_i,
  input  logic [3:0]        tc_i,
  input  logic [3:0]        req_i,
  output logic [4*(DW-2)-1:0] mode_o,
  output logic [3:0]        mask_o,
  output logic [3:0]        svc_req_o,
  output logic [4*2*DW-1:0] cur_addr_o,
  output logic [4*2*DW-1:0] cur_cnt_o,
  output logic              ctrl_off_o
);
  localparam int NCH = 4;
  localparam int SW  = $clog2(NCH);
  localparam int AW  = 2 * DW;
  localparam int MW  = DW - 2;

  logic [AW-1:0]  base_a [NCH];
  logic [AW-1:0]  cur_a  [NCH];
  logic [AW-1:0]  base_c [NCH];
  logic [AW-1:0]  cur_c  [NCH];
  logic [MW-1:0]  mode_r [NCH];
  logic [NCH-1:0] mask_r, tc_r, sreq_r;
  logic [DW-1:0]  cmd_r, rdata;
  logic           ptr;

  wire           wr_en     = cs & wr;
  wire           rd_en     = cs & rd;
  wire           chan_port = ~addr[3];
  wire [SW-1:0]  sel       = addr[SW:1];

  assign data = rd_en ? rdata : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0; cur_a[i] <= '0;
        base_c[i] <= '0; cur_c[i] <= '0;
        mode_r[i] <= '0;
      end
      mask_r <= '1;
      tc_r   <= '0;
      sreq_r <= '0;
      cmd_r  <= '0;
      ptr    <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && chan_port && sel == SW'(i)) begin
          if (!addr[0]) begin
            if (ptr) begin base_a[i][AW-1:DW] <= data; cur_a[i][AW-1:DW] <= data; end
            else     begin base_a[i][DW-1:0]  <= data; cur_a[i][DW-1:0]  <= data; end
          end else begin
            if (ptr) begin base_c[i][AW-1:DW] <= data; cur_c[i][AW-1:DW] <= data; end
            else     begin base_c[i][DW-1:0]  <= data; cur_c[i][DW-1:0]  <= data; end
          end
        end else if (tc_i[i] && mode_r[i][2]) begin
          cur_a[i] <= base_a[i];
          cur_c[i] <= base_c[i];
        end else if (step_i[i]) begin
          cur_a[i] <= mode_r[i][3] ? cur_a[i] - 1'b1 : cur_a[i] + 1'b1;
          cur_c[i] <= cur_c[i] - 1'b1;
        end
      end

      tc_r <= ((rd_en && addr == 4'h8) ? '0 : tc_r) | tc_i;
      if ((wr_en || rd_en) && chan_port) ptr <= ~ptr;

      if (wr_en) begin
        case (addr)
          4'h8: cmd_r <= data;
          4'h9: sreq_r[data[SW-1:0]] <= data[2];
          4'hA: mask_r[data[SW-1:0]] <= data[2];
          4'hB: mode_r[data[SW-1:0]] <= data[DW-1:2];
          4'hC: ptr <= 1'b0;
          4'hD: begin
            ptr    <= 1'b0;
            tc_r   <= '0;
            sreq_r <= '0;
            mask_r <= '1;
          end
          4'hE: mask_r <= '0;
          4'hF: mask_r <= data[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    logic [AW-1:0] word;
    word  = addr[0] ? cur_c[sel] : cur_a[sel];
    rdata = '0;
    if (chan_port)          rdata = ptr ? word[AW-1:DW] : word[DW-1:0];
    else if (addr == 4'h8)  rdata = DW'({req_i | sreq_r, tc_r});
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign mode_o[g*MW +: MW]     = mode_r[g];
    assign cur_addr_o[g*AW +: AW] = cur_a[g];
    assign cur_cnt_o[g*AW +: AW]  = cur_c[g];
  end

  assign mask_o     = mask_r;
  assign ctrl_off_o = cmd_r[2];
  assign svc_req_o  = (req_i | sreq_r) & ~mask_r & {NCH{~cmd_r[2]}};

  // R2
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 4'hC |=> !ptr);

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && chan_port |=> ptr != $past(ptr));

  // R6
  master_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 4'hD |=> mask_o == 4'hF && tc_r == '0 && !ptr);

  // R7
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 4'h8 && tc_i == '0 |=> tc_r == '0);

  // R8
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 4'h8 && data[2] |=> ctrl_off_o && svc_req_o == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R10
    step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i[g] && !tc_i[g] && !(wr_en && chan_port && sel == SW'(g))
      |=> cur_c[g] == $past(cur_c[g]) - 1'b1);
  end
endmodule

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, rd = 0, wr = 0, drv_en = 0;
  logic [3:0] addr = 0, step_i = 0, tc_i = 0, req_i = 0;
  logic [7:0] drv = 0;
  wire  [7:0] bus;
  logic [23:0] mode_o;
  logic [3:0]  mask_o, svc_req_o;
  logic [63:0] cur_addr_o, cur_cnt_o;
  logic        ctrl_off_o;

  assign bus = drv_en ? drv : 8'bz;
  always #10 clk = ~clk;

  dma_regfile i_dma_regfile (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .data(bus), .step_i(step_i), .tc_i(tc_i), .req_i(req_i),
    .mode_o(mode_o), .mask_o(mask_o), .svc_req_o(svc_req_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o), .ctrl_off_o(ctrl_off_o));

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  logic [5:0]  m_mode[4];
  logic [3:0]  m_mask, m_tc, m_sreq;
  logic [7:0]  m_cmd;
  bit          m_ptr;
  logic [7:0]  last_rd;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
    end
    m_mask = 4'hF; m_tc = 0; m_sreq = 0; m_cmd = 0; m_ptr = 0;
  endtask

  function automatic logic [7:0] model_read(logic [3:0] a);
    logic [15:0] w;
    if (a < 8) begin
      w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 8) return {req_i | m_sreq, m_tc};
    return 8'h00;
  endfunction

  task automatic model_step();
    bit w, r;
    w = cs && wr; r = cs && rd;
    for (int ch = 0; ch < 4; ch++) begin
      if (w && addr < 8 && addr[2:1] == ch[1:0]) begin
        if (!addr[0]) begin
          if (m_ptr) begin m_ba[ch][15:8] = drv; m_ca[ch][15:8] = drv; end
          else       begin m_ba[ch][7:0]  = drv; m_ca[ch][7:0]  = drv; end
        end else begin
          if (m_ptr) begin m_bc[ch][15:8] = drv; m_cc[ch][15:8] = drv; end
          else       begin m_bc[ch][7:0]  = drv; m_cc[ch][7:0]  = drv; end
        end
      end else if (tc_i[ch] && m_mode[ch][2]) begin
        m_ca[ch] = m_ba[ch]; m_cc[ch] = m_bc[ch];
      end else if (step_i[ch]) begin
        m_ca[ch] = m_mode[ch][3] ? m_ca[ch] - 16'd1 : m_ca[ch] + 16'd1;
        m_cc[ch] = m_cc[ch] - 16'd1;
      end
    end
    m_tc = ((r && addr == 8) ? 4'h0 : m_tc) | tc_i;
    if ((w || r) && addr < 8) m_ptr = !m_ptr;
    if (w) begin
      case (addr)
        4'h8: m_cmd = drv;
        4'h9: m_sreq[drv[1:0]] = drv[2];
        4'hA: m_mask[drv[1:0]] = drv[2];
        4'hB: m_mode[drv[1:0]] = drv[7:2];
        4'hC: m_ptr = 0;
        4'hD: begin m_ptr = 0; m_tc = 0; m_sreq = 0; m_mask = 4'hF; end
        4'hE: m_mask = 4'h0;
        4'hF: m_mask = drv[3:0];
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    chk("R5 mask", mask_o, m_mask);
    chk("R4 mode", {m_mode[3], m_mode[2], m_mode[1], m_mode[0]}, mode_o);
    chk("R8 svc", svc_req_o, (req_i | m_sreq) & ~m_mask & {4{~m_cmd[2]}});
    chk("R8 off", ctrl_off_o, m_cmd[2]);
    for (int ch = 0; ch < 4; ch++) begin
      chk("R10 addr", cur_addr_o[16*ch +: 16], m_ca[ch]);
      chk("R10 count", cur_cnt_o[16*ch +: 16], m_cc[ch]);
    end
  endtask

  task automatic cycle(string tag = "R3 read");
    #1;
    if (cs && rd) begin
      last_rd = bus;
      chk(tag, bus, model_read(addr));
    end
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    cs = 0; rd = 0; wr = 0; drv_en = 0; step_i = 0; tc_i = 0;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    cs = 1; wr = 1; rd = 0; addr = a; drv = d; drv_en = 1;
    cycle();
    idle_inputs();
  endtask

  task automatic bus_rd(logic [3:0] a, string tag);
    cs = 1; rd = 1; wr = 0; addr = a; drv_en = 0;
    cycle(tag);
    idle_inputs();
  endtask

  task automatic pulse(logic [3:0] st, logic [3:0] tc);
    step_i = st; tc_i = tc;
    cycle();
    idle_inputs();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state at the ports
    chk("R1 mask", mask_o, 4'hF);
    chk("R1 mode", mode_o, 24'h0);
    chk("R1 off", ctrl_off_o, 1'b0);
    bus_rd(4'h8, "R1 status");
    chk("R1 status literal", last_rd, 8'h00);

    // R2 byte pointer and dual load
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h2, 8'h34);
    bus_wr(4'h2, 8'h12);
    chk("R2 ch1 addr", cur_addr_o[31:16], 16'h1234);
    bus_wr(4'h3, 8'hFF);
    bus_wr(4'h3, 8'h00);
    bus_rd(4'h3, "R3 count low");
    chk("R3 count low literal", last_rd, 8'hFF);
    bus_rd(4'h3, "R3 count high");
    chk("R3 count high literal", last_rd, 8'h00);
    bus_wr(4'h4, 8'hAA);
    bus_wr(4'hC, 8'h00);
    bus_wr(4'h4, 8'hBB);
    bus_wr(4'h4, 8'hCC);
    chk("R2 ptr clear", cur_addr_o[47:32], 16'hCCBB);
    bus_wr(4'h5, 8'h02);
    bus_wr(4'h5, 8'h00);

    // R4 mode: ch1 type 01, auto, increment, single
    bus_wr(4'hB, 8'h55);
    chk("R4 ch1 field", mode_o[11:6], 6'h15);
    // ch2 decrement, no auto: type 10, dec, block -> 0b10 1 0 10 10
    bus_wr(4'hB, 8'hAA);
    chk("R4 ch2 field", mode_o[17:12], 6'h2A);

    // R5 single mask and R8 service
    req_i = 4'b0110;
    bus_wr(4'hA, 8'h01);
    chk("R5 unmask ch1", svc_req_o, 4'b0010);
    bus_wr(4'hA, 8'h02);
    bus_wr(4'hA, 8'h05);
    chk("R5 mask ch1", mask_o, 4'b1011);

    // R10 steps
    pulse(4'b0110, 4'b0000);
    pulse(4'b0110, 4'b0000);
    chk("R10 ch1 inc", cur_addr_o[31:16], 16'h1236);
    chk("R10 ch2 dec", cur_addr_o[47:32], 16'hCCB9);
    chk("R10 ch1 cnt", cur_cnt_o[31:16], 16'h00FD);

    // R11 terminal count with auto-init on ch1, without on ch2
    pulse(4'b0000, 4'b0110);
    chk("R11 reload", cur_addr_o[31:16], 16'h1234);
    chk("R11 no reload", cur_addr_o[47:32], 16'hCCB9);
    bus_rd(4'h8, "R7 status tc");
    chk("R7 status literal", last_rd, 8'h66);
    bus_rd(4'h8, "R7 status cleared");
    chk("R7 cleared literal", last_rd, 8'h60);

    // R8 command disable
    bus_wr(4'hA, 8'h02);
    bus_wr(4'h8, 8'h04);
    chk("R8 disabled", svc_req_o, 4'h0);
    bus_wr(4'h8, 8'h00);

    // R9 software request on ch3
    req_i = 4'b0000;
    bus_wr(4'h9, 8'h07);
    bus_rd(4'h8, "R9 soft request");
    chk("R9 literal", last_rd, 8'h80);
    bus_wr(4'h9, 8'h03);
    bus_rd(4'h8, "R9 soft request cleared");

    // R5 all-clear and write-all
    bus_wr(4'hE, 8'h00);
    chk("R5 clear all", mask_o, 4'h0);
    bus_wr(4'hF, 8'h0A);
    chk("R5 write all", mask_o, 4'hA);

    // R6 master reset with pointer left high and tc pending
    bus_wr(4'h9, 8'h04);
    bus_wr(4'h0, 8'h11);
    tc_i = 4'b0001;
    bus_wr(4'hD, 8'h00);
    chk("R6 mask", mask_o, 4'hF);
    bus_rd(4'h8, "R6 status");
    chk("R6 status literal", last_rd, 8'h00);
    bus_rd(4'h0, "R6 pointer low");
    chk("R6 pointer literal", last_rd, 8'h11);
    bus_rd(4'h0, "R3 addr high");

    // R10 count wrap on ch0 (count 0)
    pulse(4'b0001, 4'b0000);
    chk("R10 wrap", cur_cnt_o[15:0], 16'hFFFF);

    // R12 unused reads
    for (int a = 9; a < 16; a++) begin
      bus_rd(4'(a), "R12 unused");
      chk("R12 literal", last_rd, 8'h00);
    end

    // mixed traffic against the model
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] k;
      k = 4'($urandom_range(0, 15));
      req_i  = 4'($urandom);
      step_i = 4'($urandom) & 4'($urandom);
      tc_i   = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      addr   = 4'($urandom);
      if (addr == 4'hD && $urandom_range(0, 3) != 0) addr = 4'h3;
      drv    = 8'($urandom);
      cs     = k < 10;
      wr     = k < 5;
      rd     = (k >= 5) && (k < 10);
      drv_en = wr;
      cycle("R3 mixed read");
      idle_inputs();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule